// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block walks a DDR1 or DDR2 SDRAM device through its power-up mode-register programming. After a start pulse it samples two straps. One strap picks the memory type and the other says whether the reference clock is 40 MHz. The block then plays the fixed command script for that memory type on a small command bus. The bus has three parts: a one-hot command word, a mode-register select and a 13-bit register value. Each command is held for one clock, and a parameterised number of idle clocks separates one command from the next.

After the last command and its idle gap, the block raises a done flag that stays high until reset. While done is high, a separate output carries the periodic-refresh word for the refresh engine. This word is an enable bit and a 10-bit interval, and the interval depends on the reference-clock strap. The block does not contain the physical interface, the data path or the refresh engine.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: From reset, and until a start pulse is seen, `cmd_o`, `mreg_sel_o`, `mreg_val_o`, `done_o` and `refresh_o` are all zero. Asserting reset in the middle of a script returns every output to zero.
- R2: With the type strap high (DDR2), the issued commands, written as (command, select, value), are these eleven in this order:
  1. (precharge-all, 0, 0)
  2. (EMR2 set, 2, 0)
  3. (EMR3 set, 3, 0)
  4. (EMRS, 1, 0)
  5. (MRS, 0, 0x100)
  6. (precharge-all, 0, 0)
  7. (auto-refresh, 0, 0)
  8. (auto-refresh, 0, 0)
  9. (MRS, 0, 0xA33)
  10. (EMRS, 1, 0x382)
  11. (EMRS, 1, 0x402)
- R3: With the type strap low (DDR1), the issued commands are these five in this order:
  1. (precharge-all, 0, 0)
  2. (MRS, 0, 0x133)
  3. (EMRS, 1, 0x002)
  4. (precharge-all, 0, 0)
  5. (MRS, 0, 0x033)
- R4: Both straps are sampled in the clock cycle in which the start pulse is accepted. Later changes to the straps have no effect on the script or on the refresh word.
- R5: `cmd_o` is one-hot. The bit meanings are bit0 MRS, bit1 EMRS, bit2 auto-refresh, bit3 precharge-all, bit4 EMR2 set and bit5 EMR3 set. `mreg_sel_o` codes MR=0, EMR=1, EMR2=2 and EMR3=3. When `cmd_o` is zero, the select and the value are zero too.
- R6: The first command appears in the cycle after the start pulse is sampled. Each command lasts exactly one cycle. Exactly GAP_CYC idle cycles separate consecutive commands.
- R7: A start pulse is ignored while a script is running and after done is raised.
- R8: `done_o` rises GAP_CYC+1 cycles after the last command is issued. It then stays high, with no further commands, until reset.
- R9: `refresh_o` is zero while done is low. While done is high, its interval field in bits 9:0 holds 624 if the 40 MHz strap was high at start, and 390 otherwise.
- R10: While done is high, bit 14 of `refresh_o` (the refresh enable) is 1 and bits 13:10 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only while the block is idle |
| strap_ddr2_i | input | 1 | Memory type strap: 1 selects DDR2, 0 selects DDR1 |
| strap_ref40_i | input | 1 | Reference clock strap: 1 means 40 MHz, 0 means 25 MHz |
| cmd_o | output | 6 | One-hot command word, zero when idle |
| mreg_sel_o | output | 2 | Mode-register select for the current command |
| mreg_val_o | output | 13 | Mode-register value for the current command |
| done_o | output | 1 | Script complete, held until reset |
| refresh_o | output | 15 | Refresh enable (bit 14) and interval (bits 9:0) while done is high |

## Verification
The bench builds the block with GAP_CYC set to 3 and the refresh constants left at their defaults. The short gap keeps a full DDR2 script under fifty cycles, so every strap combination, a mid-script reset and late start pulses all fit in one short run. A gap of 3 still leaves several idle cycles in every gap, which exercises the reload of the spacing counter. The default refresh constants make the two interval values and the enable position directly observable.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

  localparam int MRV_W      = 13;
  localparam int STEP_W     = 4;
  localparam int STEPS_DDR2 = 11;
  localparam int STEPS_DDR1 = 5;

  localparam logic [5:0] CMD_NONE = 6'b000000;
  localparam logic [5:0] CMD_MRS  = 6'b000001;
  localparam logic [5:0] CMD_EMRS = 6'b000010;
  localparam logic [5:0] CMD_AREF = 6'b000100;
  localparam logic [5:0] CMD_PREA = 6'b001000;
  localparam logic [5:0] CMD_EMR2 = 6'b010000;
  localparam logic [5:0] CMD_EMR3 = 6'b100000;

  localparam logic [1:0] SEL_MR   = 2'd0;
  localparam logic [1:0] SEL_EMR  = 2'd1;
  localparam logic [1:0] SEL_EMR2 = 2'd2;
  localparam logic [1:0] SEL_EMR3 = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [5:0]       cmd;
    logic [1:0]       sel;
    logic [MRV_W-1:0] val;
  } step_t;

  function automatic step_t mk_step(input logic [5:0] c, input logic [1:0] s,
                                    input logic [MRV_W-1:0] v);
    step_t r;
    r.cmd = c;
    r.sel = s;
    r.val = v;
    return r;
  endfunction

  // Script contents per memory type; order is the required issue order.
  function automatic step_t script_step(input logic ddr2, input logic [STEP_W-1:0] idx);
    step_t r;
    r = mk_step(CMD_NONE, SEL_MR, '0);
    if (ddr2) begin
      case (idx)
        4'd0:    r = mk_step(CMD_PREA, SEL_MR,   13'h000);
        4'd1:    r = mk_step(CMD_EMR2, SEL_EMR2, 13'h000);
        4'd2:    r = mk_step(CMD_EMR3, SEL_EMR3, 13'h000);
        4'd3:    r = mk_step(CMD_EMRS, SEL_EMR,  13'h000);
        4'd4:    r = mk_step(CMD_MRS,  SEL_MR,   13'h100);
        4'd5:    r = mk_step(CMD_PREA, SEL_MR,   13'h000);
        4'd6:    r = mk_step(CMD_AREF, SEL_MR,   13'h000);
        4'd7:    r = mk_step(CMD_AREF, SEL_MR,   13'h000);
        4'd8:    r = mk_step(CMD_MRS,  SEL_MR,   13'hA33);
        4'd9:    r = mk_step(CMD_EMRS, SEL_EMR,  13'h382);
        4'd10:   r = mk_step(CMD_EMRS, SEL_EMR,  13'h402);
        default: r = mk_step(CMD_NONE, SEL_MR,   13'h000);
      endcase
    end else begin
      case (idx)
        4'd0:    r = mk_step(CMD_PREA, SEL_MR,   13'h000);
        4'd1:    r = mk_step(CMD_MRS,  SEL_MR,   13'h133);
        4'd2:    r = mk_step(CMD_EMRS, SEL_EMR,  13'h002);
        4'd3:    r = mk_step(CMD_PREA, SEL_MR,   13'h000);
        4'd4:    r = mk_step(CMD_MRS,  SEL_MR,   13'h033);
        default: r = mk_step(CMD_NONE, SEL_MR,   13'h000);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/ddr_pwrup_script.sv
module ddr_pwrup_script
  import ddr_pwrup_pkg::*;
(
  input  logic              ddr2_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o,
  output logic              last_o
);

  localparam logic [STEP_W-1:0] LAST_DDR2 = STEP_W'(STEPS_DDR2 - 1);
  localparam logic [STEP_W-1:0] LAST_DDR1 = STEP_W'(STEPS_DDR1 - 1);

  always_comb begin
    step_o = script_step(ddr2_i, idx_i);
    last_o = (idx_i == (ddr2_i ? LAST_DDR2 : LAST_DDR1));
  end

endmodule

// File: rtl/ddr_pwrup_gap.sv
module ddr_pwrup_gap #(
  parameter int GAP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);

  localparam int CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = CW'(GAP_CYC);
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == CW'(1));

endmodule

// File: rtl/ddr_pwrup_refsel.sv
module ddr_pwrup_refsel #(
  parameter int REF_W      = 10,
  parameter int REF_EN_BIT = 14,
  parameter int REF_HI     = 624,
  parameter int REF_LO     = 390
) (
  input  logic                done_i,
  input  logic                ref40_i,
  output logic [REF_EN_BIT:0] refresh_o
);

  logic [REF_W-1:0]    ival;
  logic [REF_EN_BIT:0] word;

  assign ival = ref40_i ? REF_W'(REF_HI) : REF_W'(REF_LO);

  generate
    if (REF_EN_BIT > REF_W) begin : g_pad
      assign word = {1'b1, {(REF_EN_BIT - REF_W){1'b0}}, ival};
    end else begin : g_nopad
      assign word = {1'b1, ival};
    end
  endgenerate

  assign refresh_o = done_i ? word : '0;

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_pwrup_pkg::*;
#(
  parameter int GAP_CYC    = 16,
  parameter int REF_W      = 10,
  parameter int REF_EN_BIT = 14,
  parameter int REF_HI     = 624,
  parameter int REF_LO     = 390
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  strap_ddr2_i,
  input  logic                  strap_ref40_i,
  output logic [5:0]            cmd_o,
  output logic [1:0]            mreg_sel_o,
  output logic [MRV_W-1:0]      mreg_val_o,
  output logic                  done_o,
  output logic [REF_EN_BIT:0]   refresh_o
);

  // reset: asynchronous assert, synchronous release
  logic rs_q1, rs_q2, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              ddr2_q, r40_q;
  logic              cfg_en, idx_en;
  logic              gap_load, gap_expire, last;
  step_t             step;

  ddr_pwrup_script u_script (
    .ddr2_i (ddr2_q),
    .idx_i  (idx_q),
    .step_o (step),
    .last_o (last)
  );

  ddr_pwrup_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk      (clk),
    .rst_n    (srst_n),
    .load_i   (gap_load),
    .expire_o (gap_expire)
  );

  // next state
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    cfg_en   = 1'b0;
    gap_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_CMD;
          idx_d  = '0;
          idx_en = 1'b1;
          cfg_en = 1'b1;
        end
      end
      ST_CMD: begin
        gap_load = 1'b1;
        st_d     = ST_GAP;
      end
      ST_GAP: begin
        if (gap_expire) begin
          if (last) begin
            st_d = ST_DONE;
          end else begin
            st_d   = ST_CMD;
            idx_d  = idx_q + STEP_W'(1);
            idx_en = 1'b1;
          end
        end
      end
      default: st_d = ST_DONE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ddr2_q <= 1'b0;
      r40_q  <= 1'b0;
    end else if (cfg_en) begin
      ddr2_q <= strap_ddr2_i;
      r40_q  <= strap_ref40_i;
    end
  end

  // outputs
  always_comb begin
    if (st_q == ST_CMD) begin
      cmd_o      = step.cmd;
      mreg_sel_o = step.sel;
      mreg_val_o = step.val;
    end else begin
      cmd_o      = CMD_NONE;
      mreg_sel_o = '0;
      mreg_val_o = '0;
    end
  end

  assign done_o = (st_q == ST_DONE);

  ddr_pwrup_refsel #(
    .REF_W      (REF_W),
    .REF_EN_BIT (REF_EN_BIT),
    .REF_HI     (REF_HI),
    .REF_LO     (REF_LO)
  ) u_ref (
    .done_i    (done_o),
    .ref40_i   (r40_q),
    .refresh_o (refresh_o)
  );

endmodule

// File: rtl/ddr_pwrup_chk.sv
module ddr_pwrup_chk #(
  parameter int GAP_CYC    = 16,
  parameter int REF_W      = 10,
  parameter int REF_EN_BIT = 14,
  parameter int MRV_W      = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic [5:0]          cmd_o,
  input logic [1:0]          mreg_sel_o,
  input logic [MRV_W-1:0]    mreg_val_o,
  input logic                done_o,
  input logic [REF_EN_BIT:0] refresh_o
);

  localparam int GW = $clog2(GAP_CYC + 2);

  logic [GW-1:0] idle_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      seen_q <= 1'b0;
    end else if (cmd_o != 6'd0) begin
      idle_q <= '0;
      seen_q <= 1'b1;
    end else if (idle_q != GW'(GAP_CYC + 1)) begin
      idle_q <= idle_q + GW'(1);
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_o)); // R5
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 6'd0) |-> (mreg_sel_o == 2'd0 && mreg_val_o == '0)); // R5
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 6'd0) |=> (cmd_o == 6'd0)); // R6
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 6'd0 && seen_q) |-> (idle_q == GW'(GAP_CYC))); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(refresh_o))); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd_o == 6'd0)); // R8
  AST_REF_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (refresh_o == '0)); // R9
  AST_REF_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (refresh_o[REF_EN_BIT] && refresh_o[REF_EN_BIT-1:REF_W] == '0)); // R10

endmodule

bind ddr_pwrup_seq ddr_pwrup_chk #(
  .GAP_CYC    (GAP_CYC),
  .REF_W      (REF_W),
  .REF_EN_BIT (REF_EN_BIT),
  .MRV_W      (ddr_pwrup_pkg::MRV_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_o      (cmd_o),
  .mreg_sel_o (mreg_sel_o),
  .mreg_val_o (mreg_val_o),
  .done_o     (done_o),
  .refresh_o  (refresh_o)
);

// File: tb/sim_ddr_pwrup_seq.sv
module sim_ddr_pwrup_seq;

  localparam int GAP = 3;

  logic        clk;
  logic        rst_n;
  logic        start_i, strap_ddr2_i, strap_ref40_i;
  logic [5:0]  cmd_o;
  logic [1:0]  mreg_sel_o;
  logic [12:0] mreg_val_o;
  logic        done_o;
  logic [14:0] refresh_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  ddr_pwrup_seq #(.GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .strap_ddr2_i(strap_ddr2_i), .strap_ref40_i(strap_ref40_i),
    .cmd_o(cmd_o), .mreg_sel_o(mreg_sel_o), .mreg_val_o(mreg_val_o),
    .done_o(done_o), .refresh_o(refresh_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // entry encoding: cmd<<16 | sel<<13 | val
  function automatic int enc(input int c, input int s, input int v);
    return (c << 16) | (s << 13) | v;
  endfunction

  task automatic build_list(input bit ddr2, ref int q[$]);
    q = {};
    if (ddr2) begin
      q.push_back(enc(8, 0, 0));      q.push_back(enc(16, 2, 0));
      q.push_back(enc(32, 3, 0));     q.push_back(enc(2, 1, 0));
      q.push_back(enc(1, 0, 'h100));  q.push_back(enc(8, 0, 0));
      q.push_back(enc(4, 0, 0));      q.push_back(enc(4, 0, 0));
      q.push_back(enc(1, 0, 'hA33));  q.push_back(enc(2, 1, 'h382));
      q.push_back(enc(2, 1, 'h402));
    end else begin
      q.push_back(enc(8, 0, 0));      q.push_back(enc(1, 0, 'h133));
      q.push_back(enc(2, 1, 'h002));  q.push_back(enc(8, 0, 0));
      q.push_back(enc(1, 0, 'h033));
    end
  endtask

  // behavioural reference model: 0 idle, 1 command, 2 gap, 3 done
  int m_state, m_gap, m_ref;
  int m_q[$];
  bit chk_en = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_gap = 0; m_ref = 0; m_q = {};
    end else begin
      case (m_state)
        0: if (start_i) begin
             build_list(strap_ddr2_i, m_q);
             m_ref = strap_ref40_i ? 624 : 390;
             m_state = 1;
           end
        1: begin void'(m_q.pop_front()); m_gap = GAP; m_state = 2; end
        2: begin
             m_gap--;
             if (m_gap == 0) m_state = (m_q.size() == 0) ? 3 : 1;
           end
        default: ;
      endcase
    end
  end

  int log_q[$];

  always @(negedge clk) begin
    if (rst_n && cmd_o != 6'd0) log_q.push_back(enc(cmd_o, mreg_sel_o, mreg_val_o));
    if (rst_n && chk_en && !finished) begin
      int exp_bus, got_bus, exp_ref;
      exp_bus = (m_state == 1) ? m_q[0] : 0;
      got_bus = enc(cmd_o, mreg_sel_o, mreg_val_o);
      total++;
      if (got_bus !== exp_bus) begin
        bad++;
        $display("FAIL R6 bus cycle: got %h exp %h", got_bus, exp_bus);
      end
      total++;
      if (done_o !== (m_state == 3)) begin
        bad++;
        $display("FAIL R8 done: got %0b exp %0b", done_o, (m_state == 3));
      end
      exp_ref = (m_state == 3) ? ('h4000 | m_ref) : 0;
      total++;
      if (refresh_o !== exp_ref[14:0]) begin
        bad++;
        $display("FAIL R9 refresh: got %h exp %h", refresh_o, exp_ref);
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    chk_en = 0;
    rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    log_q = {};
    chk_en = 1;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    check(tag, done_o, 1);
  endtask

  task automatic check_log(input bit ddr2, input string tag);
    int exp_q[$];
    build_list(ddr2, exp_q);
    check({tag, " count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      check({tag, " entry"}, log_q[i], exp_q[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout exp done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; strap_ddr2_i = 1'b1; strap_ref40_i = 1'b1;
    #1;
    @(negedge clk);
    // R1: outputs quiet in reset and with no start
    check("R1 reset cmd", cmd_o, 0);
    check("R1 reset done", done_o, 0);
    check("R1 reset refresh", refresh_o, 0);
    do_reset();
    repeat (10) @(negedge clk);
    check("R1 no start no cmd", log_q.size(), 0);

    // DDR2, 40 MHz; straps flipped and start repeated mid-run (R4, R7)
    pulse_start();
    repeat (5) @(negedge clk);
    strap_ddr2_i = 1'b0; strap_ref40_i = 1'b0;
    pulse_start();
    wait_done("R8 done DDR2");
    check_log(1'b1, "R2 DDR2 script R4");
    check("R4 R9 refresh 40M", refresh_o, 'h4000 | 624);
    // R7: start after done has no effect
    pulse_start();
    repeat (20) @(negedge clk);
    check("R7 no cmd after done", log_q.size(), 11);
    check("R8 done held", done_o, 1);

    // DDR1, 25 MHz
    do_reset();
    strap_ddr2_i = 1'b0; strap_ref40_i = 1'b0;
    pulse_start();
    wait_done("R8 done DDR1");
    check_log(1'b0, "R3 DDR1 script");
    check("R9 refresh 25M", refresh_o, 'h4000 | 390);

    // DDR1, 40 MHz
    do_reset();
    strap_ddr2_i = 1'b0; strap_ref40_i = 1'b1;
    pulse_start();
    wait_done("R8 done DDR1 40M");
    check_log(1'b0, "R3 DDR1 40M");
    check("R10 enable and pad", int'(refresh_o[14:10]), 'h10);

    // DDR2, 25 MHz
    do_reset();
    strap_ddr2_i = 1'b1; strap_ref40_i = 1'b0;
    pulse_start();
    wait_done("R8 done DDR2 25M");
    check_log(1'b1, "R2 DDR2 25M");
    check("R9 refresh DDR2 25M", refresh_o, 'h4000 | 390);

    // R1: reset in the middle of a script
    do_reset();
    strap_ddr2_i = 1'b1;
    pulse_start();
    repeat (10) @(negedge clk);
    chk_en = 0;
    rst_n = 1'b0;
    #1;
    check("R1 mid reset cmd", cmd_o, 0);
    check("R1 mid reset done", done_o, 0);
    check("R1 mid reset refresh", refresh_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule